// File: doc/BRIEF.md
# Card Interface Mode Sequencer

This block is the top-level controller of a smart-card interface. It tracks which of eight operating states the interface is in: power-off, idle, low-power sleep, wake-up, activation, active, deactivation and fault. From that state it drives the enables for the crystal oscillator, the card supply, the card I/O contact, the card clock and the card reset release, the host data lines and an interrupt towards the host. Its inputs are a supply-good flag, an active-low activation command, a mode pin (LOW requests sleep), a card presence flag and a fault flag.

The card contacts are brought up in a fixed order during activation and taken down in the reverse order during deactivation. Each step lasts a parameterised number of clock cycles. Supply loss, card removal, a fault and a sleep request while the card is powered all lead through a full deactivation before the new state is entered. Leaving sleep takes a fixed number of cycles of the slow host clock output. The host clock arrives as a one-cycle tick per host clock period.

Top module: `card_mode_seq`

## Requirements
- R1: After reset the state is power-off (code 0) with every output low. The state stays at power-off while supply_ok_i is low, and moves to idle on the first edge at which supply_ok_i is high.
- R2: In idle (code 1) the oscillator enable is high, and all card contact enables, the host line enable and the interrupt are low.
- R3: In idle with mode_i high, card_present_i high, fault_i low and act_cmd_ni low, the next state is activation (code 3). Activation runs four steps of STEP_CYCLES cycles each. Step 0 enables the supply; step 1 adds the I/O contact; step 2 adds the clock; step 3 releases the reset. The state then becomes active (code 4), with all contact enables and the host line enable high.
- R4: A low mode_i in idle gives sleep (code 2) on the next edge. In sleep the oscillator and all contacts are off. While mode_i stays low, act_cmd_ni has no effect and the state stays in sleep.
- R5: A low mode_i in activation or active mode (supply good, card present, no fault) starts a deactivation (code 5), and the state becomes sleep when that deactivation ends.
- R6: Deactivation runs four steps of STEP_CYCLES cycles each, in this order. Step 0 holds the card in reset; step 1 also stops the clock; step 2 also disables the I/O contact; step 3 also turns off the supply. The state then becomes the deactivation target.
- R7: A high mode_i in sleep gives wake-up (code 7), during which the oscillator stays off. After WAKE_TICKS pulses of hclk_tick_i the state becomes idle. A low mode_i during wake-up returns the state to sleep, and the wake-up count starts again on the next wake-up.
- R8: A low supply_ok_i in activation or active mode starts a deactivation whose target is power-off. A low supply_ok_i during deactivation changes the target to power-off. In idle, sleep, wake-up or fault, a low supply_ok_i gives power-off on the next edge.
- R9: Card removal or a high fault_i in activation or active mode starts a deactivation whose target is the fault state (code 6). irq_o is high exactly while the state is fault.
- R10: The fault state is left for idle only when act_cmd_ni is high and fault_i is low.
- R11: A high act_cmd_ni in active mode starts a deactivation whose target is idle.
- R12: The state output uses these codes: power-off 0, idle 1, sleep 2, activation 3, active 4, deactivation 5, fault 6, wake-up 7. Power-off, sleep and wake-up are the only states with the oscillator enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Host supply is within range |
| act_cmd_ni | input | 1 | Activation command, active low |
| mode_i | input | 1 | Operating mode pin, LOW requests sleep |
| card_present_i | input | 1 | Card is inserted |
| fault_i | input | 1 | Card-side fault flag |
| hclk_tick_i | input | 1 | One-cycle pulse per host clock output period |
| state_o | output | 3 | Current state code |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| vcc_en_o | output | 1 | Card supply enable |
| io_en_o | output | 1 | Card I/O contact enable |
| clk_en_o | output | 1 | Card clock enable |
| rst_rel_o | output | 1 | Card reset released |
| host_en_o | output | 1 | Host data lines driven (otherwise high impedance) |
| irq_o | output | 1 | Interrupt to host |

## Verification
The bench builds the block with STEP_CYCLES set to 2 and WAKE_TICKS left at 96. A host tick arrives every fourth clock, so each contact ramp takes 8 cycles and a wake-up about 384. With these values many complete activate, deactivate and wake cycles fit into one random run. The short steps also make supply loss, card removal and mode changes fall in every step of both ramps, including the cycle in which a ramp completes.

// File: rtl/cms_pkg.sv
package cms_pkg;

    // Number of contact steps in a ramp: supply, I/O, clock, reset release.
    localparam int unsigned NUM_STEPS = 4;
    localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_SLEEP = 3'd2,
        ST_ACT   = 3'd3,
        ST_ON    = 3'd4,
        ST_DEACT = 3'd5,
        ST_FAULT = 3'd6,
        ST_WAKE  = 3'd7
    } cms_state_e;

    typedef struct packed {
        logic vcc;
        logic io;
        logic clk;
        logic rst_rel;
    } cms_contacts_t;

    typedef struct packed {
        cms_state_e state;
        cms_state_e tgt;
    } cms_fsm_t;

endpackage

// File: rtl/cms_step_timer.sv
module cms_step_timer
    import cms_pkg::*;
#(
    parameter int unsigned STEP_CYCLES = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              run_i,
    output logic [STEP_W-1:0] step_o,
    output logic              done_o
);

    localparam int unsigned CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(STEP_CYCLES - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NUM_STEPS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [STEP_W-1:0] step;
    } timer_t;

    timer_t q, d;

    always_comb begin
        d = q;
        if (clear_i) begin
            d.cnt  = '0;
            d.step = '0;
        end else if (run_i) begin
            if (q.cnt == CNT_LAST) begin
                d.cnt  = '0;
                d.step = q.step + STEP_W'(1);
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign step_o = q.step;
    assign done_o = run_i && (q.step == STEP_LAST) && (q.cnt == CNT_LAST);

endmodule

// File: rtl/cms_wake_counter.sv
module cms_wake_counter #(
    parameter int unsigned WAKE_TICKS = 96
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic tick_i,
    output logic done_o
);

    localparam int unsigned WW = $clog2(WAKE_TICKS + 1);
    localparam logic [WW-1:0] LIMIT = WW'(WAKE_TICKS);

    logic [WW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!enable_i) begin
            cnt_d = '0;
        end else if (tick_i && (cnt_q != LIMIT)) begin
            cnt_d = cnt_q + WW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = enable_i && (cnt_q == LIMIT);

endmodule

// File: rtl/cms_contact_map.sv
module cms_contact_map
    import cms_pkg::*;
(
    input  cms_state_e        state_i,
    input  logic [STEP_W-1:0] step_i,
    output cms_contacts_t     contacts_o
);

    logic [NUM_STEPS-1:0] en;

    // Contact index i: 0 supply, 1 I/O, 2 clock, 3 reset release.
    // Ramp-up turns contact i on from step i; ramp-down keeps it while
    // step + i is below the last step index.
    for (genvar i = 0; i < NUM_STEPS; i++) begin : g_pin
        assign en[i] = (state_i == ST_ON)
                     | ((state_i == ST_ACT)   & (32'(step_i) >= 32'(i)))
                     | ((state_i == ST_DEACT) & ((32'(step_i) + 32'(i)) < 32'(NUM_STEPS - 1)));
    end

    assign contacts_o.vcc     = en[0];
    assign contacts_o.io      = en[1];
    assign contacts_o.clk     = en[2];
    assign contacts_o.rst_rel = en[3];

endmodule

// File: rtl/card_mode_seq.sv
module card_mode_seq
    import cms_pkg::*;
#(
    parameter int unsigned STEP_CYCLES = 4,
    parameter int unsigned WAKE_TICKS  = 96
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       supply_ok_i,
    input  logic       act_cmd_ni,
    input  logic       mode_i,
    input  logic       card_present_i,
    input  logic       fault_i,
    input  logic       hclk_tick_i,
    output logic [2:0] state_o,
    output logic       xtal_en_o,
    output logic       vcc_en_o,
    output logic       io_en_o,
    output logic       clk_en_o,
    output logic       rst_rel_o,
    output logic       host_en_o,
    output logic       irq_o
);

    cms_fsm_t          q, d;
    logic [STEP_W-1:0] step;
    logic              ramp_done;
    logic              wake_done;
    logic              ramping;
    cms_contacts_t     contacts;
    cms_state_e        tgt_eff;

    assign ramping = (q.state == ST_ACT) || (q.state == ST_DEACT);

    cms_step_timer #(
        .STEP_CYCLES (STEP_CYCLES)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (d.state != q.state),
        .run_i   (ramping),
        .step_o  (step),
        .done_o  (ramp_done)
    );

    cms_wake_counter #(
        .WAKE_TICKS (WAKE_TICKS)
    ) u_wake (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .enable_i (q.state == ST_WAKE),
        .tick_i   (hclk_tick_i),
        .done_o   (wake_done)
    );

    cms_contact_map u_map (
        .state_i    (q.state),
        .step_i     (step),
        .contacts_o (contacts)
    );

    always_comb begin
        d       = q;
        tgt_eff = supply_ok_i ? q.tgt : ST_OFF;
        unique case (q.state)
            ST_OFF: begin
                if (supply_ok_i) d.state = ST_IDLE;
            end
            ST_IDLE: begin
                if (!supply_ok_i) begin
                    d.state = ST_OFF;
                end else if (!mode_i) begin
                    d.state = ST_SLEEP;
                end else if (!act_cmd_ni && card_present_i && !fault_i) begin
                    d.state = ST_ACT;
                end
            end
            ST_SLEEP: begin
                if (!supply_ok_i) begin
                    d.state = ST_OFF;
                end else if (mode_i) begin
                    d.state = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (!supply_ok_i) begin
                    d.state = ST_OFF;
                end else if (!mode_i) begin
                    d.state = ST_SLEEP;
                end else if (wake_done) begin
                    d.state = ST_IDLE;
                end
            end
            ST_ACT, ST_ON: begin
                if (!supply_ok_i) begin
                    d.state = ST_DEACT;
                    d.tgt   = ST_OFF;
                end else if (!card_present_i || fault_i) begin
                    d.state = ST_DEACT;
                    d.tgt   = ST_FAULT;
                end else if (!mode_i) begin
                    d.state = ST_DEACT;
                    d.tgt   = ST_SLEEP;
                end else if ((q.state == ST_ON) && act_cmd_ni) begin
                    d.state = ST_DEACT;
                    d.tgt   = ST_IDLE;
                end else if ((q.state == ST_ACT) && ramp_done) begin
                    d.state = ST_ON;
                end
            end
            ST_DEACT: begin
                d.tgt = tgt_eff;
                if (ramp_done) d.state = tgt_eff;
            end
            ST_FAULT: begin
                if (!supply_ok_i) begin
                    d.state = ST_OFF;
                end else if (act_cmd_ni && !fault_i) begin
                    d.state = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.state <= ST_OFF;
            q.tgt   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign state_o   = q.state;
    assign xtal_en_o = !((q.state == ST_OFF) || (q.state == ST_SLEEP) || (q.state == ST_WAKE));
    assign vcc_en_o  = contacts.vcc;
    assign io_en_o   = contacts.io;
    assign clk_en_o  = contacts.clk;
    assign rst_rel_o = contacts.rst_rel;
    assign host_en_o = (q.state == ST_ON);
    assign irq_o     = (q.state == ST_FAULT);

endmodule

// File: rtl/cms_checker.sv
module cms_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       supply_ok_i,
    input logic       act_cmd_ni,
    input logic       mode_i,
    input logic       card_present_i,
    input logic       fault_i,
    input logic [2:0] state_o,
    input logic       xtal_en_o,
    input logic       vcc_en_o,
    input logic       io_en_o,
    input logic       clk_en_o,
    input logic       rst_rel_o,
    input logic       host_en_o,
    input logic       irq_o
);

    AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd0 && !supply_ok_i) |=> (state_o == 3'd0)); // R1

    AST_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd2 && !mode_i && supply_ok_i) |=> (state_o == 3'd2)); // R4

    AST_ACTIVE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd4) |-> (vcc_en_o && io_en_o && clk_en_o && rst_rel_o && host_en_o)); // R3

    AST_RAMP_UP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd3) |-> (vcc_en_o && (io_en_o || !clk_en_o) && (clk_en_o || !rst_rel_o))); // R3

    AST_MODE_DEACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd4 && supply_ok_i && card_present_i && !fault_i && !mode_i)
        |=> (state_o == 3'd5)); // R5

    AST_DEACT_RESET_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd5) |-> (!rst_rel_o && !host_en_o)); // R6

    AST_WAKE_XTAL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd7 || state_o == 3'd2) |-> !xtal_en_o); // R7

    AST_SUPPLY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd4 && !supply_ok_i) |=> (state_o == 3'd5)); // R8

    AST_IRQ_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> ($past(state_o) == 3'd5)); // R9

    AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd6 && supply_ok_i && (fault_i || !act_cmd_ni)) |=> (state_o == 3'd6)); // R10

endmodule

bind card_mode_seq cms_checker u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .supply_ok_i    (supply_ok_i),
    .act_cmd_ni     (act_cmd_ni),
    .mode_i         (mode_i),
    .card_present_i (card_present_i),
    .fault_i        (fault_i),
    .state_o        (state_o),
    .xtal_en_o      (xtal_en_o),
    .vcc_en_o       (vcc_en_o),
    .io_en_o        (io_en_o),
    .clk_en_o       (clk_en_o),
    .rst_rel_o      (rst_rel_o),
    .host_en_o      (host_en_o),
    .irq_o          (irq_o)
);

// File: tb/sim_card_mode_seq.sv
module sim_card_mode_seq;

    localparam int S = 2;
    localparam int W = 96;

    logic clk = 1'b0, rst_n = 1'b0;
    logic supply = 1'b0, cmd_n = 1'b1, mode = 1'b1, pres = 1'b1, flt = 1'b0, tick = 1'b0;
    logic [2:0] state;
    logic xtal, vcc, io, cclk, rrel, host, irq;

    always #5 clk = ~clk;

    card_mode_seq #(.STEP_CYCLES(S), .WAKE_TICKS(W)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply), .act_cmd_ni(cmd_n),
        .mode_i(mode), .card_present_i(pres), .fault_i(flt), .hclk_tick_i(tick),
        .state_o(state), .xtal_en_o(xtal), .vcc_en_o(vcc), .io_en_o(io),
        .clk_en_o(cclk), .rst_rel_o(rrel), .host_en_o(host), .irq_o(irq)
    );

    int vec = 0, bad = 0;
    string tag = "R1";

    // Host clock tick: one pulse every fourth cycle.
    int tdiv = 0;
    always @(posedge clk) begin
        #1;
        tdiv = (tdiv + 1) % 4;
        tick = (tdiv == 0);
    end

    // Requirement-level reference model.
    int m_state = 0, m_tgt = 1, m_cnt = 0, m_step = 0, m_wake = 0;
    int nx, nt;
    bit rdone, wdone;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_tgt = 1; m_cnt = 0; m_step = 0; m_wake = 0;
        end else begin
            nx = m_state; nt = m_tgt;
            rdone = (m_state == 3 || m_state == 5) && m_step == 3 && m_cnt == S - 1;
            wdone = (m_state == 7) && (m_wake == W);
            case (m_state)
                0: if (supply) nx = 1;
                1: if (!supply) nx = 0; else if (!mode) nx = 2;
                   else if (!cmd_n && pres && !flt) nx = 3;
                2: if (!supply) nx = 0; else if (mode) nx = 7;
                7: if (!supply) nx = 0; else if (!mode) nx = 2; else if (wdone) nx = 1;
                3, 4: begin
                    if (!supply) begin nx = 5; nt = 0; end
                    else if (!pres || flt) begin nx = 5; nt = 6; end
                    else if (!mode) begin nx = 5; nt = 2; end
                    else if (m_state == 4 && cmd_n) begin nx = 5; nt = 1; end
                    else if (m_state == 3 && rdone) nx = 4;
                end
                5: begin
                    if (!supply) nt = 0;
                    if (rdone) nx = nt;
                end
                6: if (!supply) nx = 0; else if (cmd_n && !flt) nx = 1;
                default: nx = m_state;
            endcase
            if (nx != m_state) begin
                m_cnt = 0; m_step = 0;
            end else if (m_state == 3 || m_state == 5) begin
                if (m_cnt == S - 1) begin m_cnt = 0; m_step = m_step + 1; end
                else m_cnt = m_cnt + 1;
            end
            if (m_state != 7) m_wake = 0;
            else if (tick && m_wake < W) m_wake = m_wake + 1;
            m_state = nx; m_tgt = nt;
        end
    end

    // Expected {xtal, vcc, io, clk, rst_rel, host, irq} for a model state.
    function automatic logic [6:0] expv(int st, int stp);
        logic x, v, i, c, r;
        x = !(st == 0 || st == 2 || st == 7);
        v = 0; i = 0; c = 0; r = 0;
        if (st == 4) begin v = 1; i = 1; c = 1; r = 1; end
        if (st == 3) begin v = 1; i = (stp >= 1); c = (stp >= 2); r = (stp >= 3); end
        if (st == 5) begin c = (stp == 0); i = (stp <= 1); v = (stp <= 2); end
        return {x, v, i, c, r, (st == 4), (st == 6)};
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            vec++;
            if (state !== 3'(m_state) || {xtal, vcc, io, cclk, rrel, host, irq} !== expv(m_state, m_step)) begin
                bad++;
                $display("FAIL %s: state=%0d outs=%b expected state=%0d outs=%b",
                         tag, state, {xtal, vcc, io, cclk, rrel, host, irq}, m_state, expv(m_state, m_step));
            end
        end
    end

    task automatic go(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_st(string t, int e);
        vec++;
        if (state !== 3'(e)) begin
            bad++;
            $display("FAIL %s: state=%0d expected %0d", t, state, e);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    endtask

    initial begin
        #(100000 * 10);
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        go(3);
        // R1: reset state, held in power-off without supply
        vec++;
        if ({state, xtal, vcc, io, cclk, rrel, host, irq} !== 10'd0) begin
            bad++;
            $display("FAIL R1: outputs %b during reset expected all zero", {state, xtal, vcc, io, cclk, rrel, host, irq});
        end
        rst_n = 1'b1;
        go(6);  expect_st("R1", 0);
        tag = "R2"; supply = 1'b1; go(4); expect_st("R2", 1);
        // R4: sleep ignores activation command
        tag = "R4"; mode = 1'b0; cmd_n = 1'b0; go(12); expect_st("R4", 2);
        cmd_n = 1'b1;
        // R7: wake-up with an interrupting mode blip
        tag = "R7"; mode = 1'b1; go(100); expect_st("R7", 7);
        mode = 1'b0; go(3); expect_st("R7", 2);
        mode = 1'b1; go(420); expect_st("R7", 1);
        // R3: activation ramp
        tag = "R3"; cmd_n = 1'b0; go(1); expect_st("R3", 3);
        go(4 * S); expect_st("R3", 4);
        // R11, R6: host release ramps down to idle
        tag = "R11"; cmd_n = 1'b1; go(1); expect_st("R6", 5);
        go(4 * S + 1); expect_st("R11", 1);
        // R5: sleep request while active
        tag = "R5"; cmd_n = 1'b0; go(4 * S + 4); mode = 1'b0; go(4 * S + 3); expect_st("R5", 2);
        cmd_n = 1'b1; mode = 1'b1; go(420); expect_st("R5", 1);
        // R9, R10: card removal during activation
        tag = "R9"; cmd_n = 1'b0; go(3); pres = 1'b0; go(4 * S + 3); expect_st("R9", 6);
        tag = "R10"; pres = 1'b1; go(5); expect_st("R10", 6);
        cmd_n = 1'b1; flt = 1'b1; go(5); expect_st("R10", 6);
        flt = 1'b0; go(2); expect_st("R10", 1);
        // R9: fault flag while active
        tag = "R9"; cmd_n = 1'b0; go(4 * S + 4); flt = 1'b1; go(4 * S + 3); expect_st("R9", 6);
        flt = 1'b0; cmd_n = 1'b1; go(2); expect_st("R10", 1);
        // R8: supply loss while active and in idle
        tag = "R8"; cmd_n = 1'b0; go(4 * S + 4); supply = 1'b0; go(4 * S + 3); expect_st("R8", 0);
        cmd_n = 1'b1; supply = 1'b1; go(3); expect_st("R8", 1);
        supply = 1'b0; go(1); expect_st("R8", 0);
        supply = 1'b1; go(2);
        // R12: random mix, every cycle checked against the model
        tag = "R12";
        for (int k = 0; k < 200; k++) begin
            supply = ($urandom % 16) != 0;
            mode   = ($urandom % 5) != 0;
            cmd_n  = ($urandom % 3) == 0;
            pres   = ($urandom % 8) != 0;
            flt    = ($urandom % 12) == 0;
            go(1 + ($urandom % 40));
        end
        finish_run();
    end

endmodule